// File: doc/BRIEF.md
# ADC result and status host bus interface

This block sits between the conversion core of a successive-approximation converter and a host processor's parallel bus. When the core finishes a conversion, it pulses a result-valid strobe with the result word. The block stores that word left-justified in an output buffer, so the host can read a finished result while the core is already tracking or converting the next sample. The conversion rate is not reduced by the host's reads.

The host reads through a chip-select, an active-low read strobe, one address line and a width-select pin. With the address line low, the host reads a status byte. This byte carries an active-low end-of-conversion flag, a next-byte indicator and the core's phase flags. With the address line high, the host reads the result. In wide mode the whole result arrives in one 16-bit read. In byte mode the result arrives as a high byte and a low byte on the lower lane. Successive byte reads alternate between the two until a new result is loaded.

The bus is presented as a data vector plus one output-enable per byte lane. The pad ring turns these into tri-state drivers, so a lane with its enable low is high impedance. The resolution parameter may be 12, 14 or 16 bits.

Top module: `adc_hostbus_if`

## Requirements
- R1: Wide data read: while `cs_n`, `rd_n` are low with `addr_sel`=1 and `wide_sel`=1, `bus_dout[15:0]` carries the buffered result left-justified (MSB on bit 15, zeros below the LSB), and both `bus_oe_hi` and `bus_oe_lo` are 1.
- R2: Byte-mode high read: with `addr_sel`=1, `wide_sel`=0 and the pointer at the high byte, `bus_dout[7:0]` equals bits 15..8 of the left-justified result, and `bus_oe_hi`=0 with `bus_dout[15:8]`=0.
- R3: Byte-mode low read: with the pointer at the low byte, `bus_dout[7:0]` equals bits 7..0 of the left-justified result. The remaining result bits sit on top, with 16−RES_W zeros below them.
- R4: Completing a byte-mode data read flips the pointer, so reads keep alternating high, low, high and so on. Loading a new result returns the pointer to the high byte. Wide data reads and status reads leave the pointer unchanged.
- R5: With `addr_sel`=0, the status byte is driven on bits 7..0, and `bus_oe_hi`=0.
- R6: Status bit 0 is 0 from the cycle after a result load until the end of the next completed read of either kind. It is 1 after reset.
- R7: Status bit 2 gives the next byte-mode data read: 0 means the high byte, 1 means the low byte.
- R8: Status bit 3 mirrors `acq_settle_n`, bit 5 mirrors `trk_busy`, bit 6 mirrors `cnv_busy` and bit 7 mirrors `cal_busy`. Bits 1 and 4 read as 0.
- R9: The buffered result changes only on a result load. Reads and phase activity never change it.
- R10: Both lane enables are 0 unless `cs_n` and `rd_n` are both 0. A read completes on the cycle in which that access condition ends.
- R11: If a result load coincides with a completing read, the load wins. Status bit 0 stays 0 and the pointer goes to the high byte.
- R12: After reset, the buffer holds 0, status bit 0 is 1 and the pointer selects the high byte.
- R13: `res_ready` is always 1. The core side has no back-pressure, and every `res_valid` cycle overwrites the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Core result valid pulse |
| res_ready | output | 1 | Always high, result always accepted |
| res_word | input | RES_W | Result word from the core |
| trk_busy | input | 1 | Core is tracking |
| cnv_busy | input | 1 | Core is converting |
| cal_busy | input | 1 | Core is calibrating |
| acq_settle_n | input | 1 | Low once acquisition has settled |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| addr_sel | input | 1 | 0 selects status, 1 selects data |
| wide_sel | input | 1 | 1 selects 16-bit reads, 0 selects byte reads |
| bus_dout | output | 16 | Read data |
| bus_oe_hi | output | 1 | Drive enable for bits 15..8 |
| bus_oe_lo | output | 1 | Drive enable for bits 7..0 |

## Verification
A table of result words walks through each pattern. The words are all ones, all zeros, alternating bits, and values with only a top or bottom bit set. Each word is read wide and then as three byte reads. A lane swap, a wrong pad position or a pointer that fails to flip shows up as a mismatch on a specific byte. Directed sequences interleave status reads with data reads. They show that only byte-mode data reads move the pointer, and that any read releases the end-of-conversion flag. A load that collides with a completing read separates load priority from read priority.

// File: rtl/adc_hostbus_pkg.sv
package adc_hostbus_pkg;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  localparam int ST_EOC    = 0;
  localparam int ST_PTR    = 2;
  localparam int ST_SETTLE = 3;
  localparam int ST_TRK    = 5;
  localparam int ST_CNV    = 6;
  localparam int ST_CAL    = 7;

  typedef enum logic {
    PTR_HI = 1'b0,
    PTR_LO = 1'b1
  } byte_ptr_e;

  typedef struct packed {
    logic cal;
    logic cnv;
    logic trk;
    logic settle_n;
  } phase_t;
endpackage

// File: rtl/hb_rd_strobe.sv
module hb_rd_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic addr_sel,
  input  logic wide_sel,
  output logic access_on,
  output logic done_any,
  output logic done_byte
);
  logic active_q;
  logic addr_q;
  logic wide_q;

  assign access_on = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= 1'b0;
      wide_q   <= 1'b0;
    end else begin
      active_q <= access_on;
      if (access_on) begin
        addr_q <= addr_sel;
        wide_q <= wide_sel;
      end
    end
  end

  // a read counts when the access window closes
  assign done_any  = active_q && !access_on;
  assign done_byte = done_any && addr_q && !wide_q;

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    access_on |=> (done_any || access_on)) else $error("done"); // R10
endmodule

// File: rtl/hb_result_buf.sv
module hb_result_buf
  import adc_hostbus_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_word,
  input  logic             rd_any,
  input  logic             rd_byte,
  output logic [BUS_W-1:0] just_word,
  output logic             eoc_n,
  output byte_ptr_e        ptr
);
  localparam int PAD_W = BUS_W - RES_W;

  logic [BUS_W-1:0] aligned;

  generate
    if (PAD_W == 0) begin : g_full
      assign aligned = res_word;
    end else begin : g_pad
      assign aligned = {res_word, {PAD_W{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      just_word <= '0;
      eoc_n     <= 1'b1;
      ptr       <= PTR_HI;
    end else if (res_valid) begin
      // load wins over a read finishing this cycle
      just_word <= aligned;
      eoc_n     <= 1'b0;
      ptr       <= PTR_HI;
    end else begin
      if (rd_any)  eoc_n <= 1'b1;
      if (rd_byte) ptr   <= (ptr == PTR_HI) ? PTR_LO : PTR_HI;
    end
  end

  AST_LOAD_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !eoc_n) else $error("eoc"); // R6
  AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (ptr == PTR_HI)) else $error("ptr"); // R11
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && !res_valid) |=> eoc_n) else $error("rel"); // R6
  AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_byte && !res_valid) |=> (ptr != $past(ptr))) else $error("flip"); // R4
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(just_word)) else $error("hold"); // R9
endmodule

// File: rtl/hb_bus_mux.sv
module hb_bus_mux
  import adc_hostbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_on,
  input  logic             addr_sel,
  input  logic             wide_sel,
  input  logic [BUS_W-1:0] just_word,
  input  byte_ptr_e        ptr,
  input  logic             eoc_n,
  input  phase_t           phase,
  output logic [BUS_W-1:0] dout,
  output logic             oe_hi,
  output logic             oe_lo
);
  logic [BYTE_W-1:0] status;
  logic [BYTE_W-1:0] byte_sel;

  always_comb begin
    status            = '0;
    status[ST_EOC]    = eoc_n;
    status[ST_PTR]    = (ptr == PTR_LO);
    status[ST_SETTLE] = phase.settle_n;
    status[ST_TRK]    = phase.trk;
    status[ST_CNV]    = phase.cnv;
    status[ST_CAL]    = phase.cal;
  end

  assign byte_sel = (ptr == PTR_HI) ? just_word[BUS_W-1:BYTE_W]
                                    : just_word[BYTE_W-1:0];

  always_comb begin
    dout = '0;
    if (access_on) begin
      if (!addr_sel)     dout = {{BYTE_W{1'b0}}, status};
      else if (wide_sel) dout = just_word;
      else               dout = {{BYTE_W{1'b0}}, byte_sel};
    end
  end

  assign oe_lo = access_on;
  assign oe_hi = access_on && addr_sel && wide_sel;

  AST_HI_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_hi |-> (dout[BUS_W-1:BYTE_W] == '0)) else $error("hi"); // R5
  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    oe_hi |-> oe_lo) else $error("lane"); // R10
endmodule

// File: rtl/adc_hostbus_if.sv
module adc_hostbus_if
  import adc_hostbus_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_word,
  input  logic             trk_busy,
  input  logic             cnv_busy,
  input  logic             cal_busy,
  input  logic             acq_settle_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             addr_sel,
  input  logic             wide_sel,
  output logic [15:0]      bus_dout,
  output logic             bus_oe_hi,
  output logic             bus_oe_lo
);
  logic             access_on;
  logic             done_any;
  logic             done_byte;
  logic [BUS_W-1:0] just_word;
  logic             eoc_n;
  byte_ptr_e        ptr;
  phase_t           phase;

  assign res_ready = 1'b1;
  assign phase = '{cal: cal_busy, cnv: cnv_busy, trk: trk_busy, settle_n: acq_settle_n};

  hb_rd_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .addr_sel(addr_sel), .wide_sel(wide_sel),
    .access_on(access_on), .done_any(done_any), .done_byte(done_byte)
  );

  hb_result_buf #(.RES_W(RES_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_word(res_word),
    .rd_any(done_any), .rd_byte(done_byte),
    .just_word(just_word), .eoc_n(eoc_n), .ptr(ptr)
  );

  hb_bus_mux u_mux (
    .clk(clk), .rst_n(rst_n), .access_on(access_on),
    .addr_sel(addr_sel), .wide_sel(wide_sel), .just_word(just_word),
    .ptr(ptr), .eoc_n(eoc_n), .phase(phase),
    .dout(bus_dout), .oe_hi(bus_oe_hi), .oe_lo(bus_oe_lo)
  );

  AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !(bus_oe_hi || bus_oe_lo)) else $error("idle"); // R10
endmodule

// File: tb/adc_hostbus_if_test.sv
module adc_hostbus_if_test;
  localparam int RES_W = 12;
  localparam int NVEC  = 5;
  localparam logic [RES_W-1:0] VEC [NVEC] = '{12'hFFF, 12'h000, 12'hA5C, 12'h801, 12'h123};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic res_ready;
  logic [RES_W-1:0] res_word = '0;
  logic trk_busy = 1'b1, cnv_busy = 1'b0, cal_busy = 1'b0, acq_settle_n = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, addr_sel = 1'b0, wide_sel = 1'b0;
  logic [15:0] bus_dout;
  logic bus_oe_hi, bus_oe_lo;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_hostbus_if #(.RES_W(RES_W)) uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_word(res_word), .trk_busy(trk_busy), .cnv_busy(cnv_busy),
    .cal_busy(cal_busy), .acq_settle_n(acq_settle_n), .cs_n(cs_n), .rd_n(rd_n),
    .addr_sel(addr_sel), .wide_sel(wide_sel), .bus_dout(bus_dout),
    .bus_oe_hi(bus_oe_hi), .bus_oe_lo(bus_oe_lo)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic eoc, input logic lo_next);
    return {cal_busy, cnv_busy, trk_busy, 1'b0, acq_settle_n, lo_next, 1'b0, eoc};
  endfunction

  task automatic load(input logic [RES_W-1:0] w);
    @(negedge clk); res_valid = 1'b1; res_word = w;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic rd(input logic a, input logic wd, input logic coll, input logic [RES_W-1:0] cw,
                    output logic [15:0] d, output logic [1:0] oe);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr_sel = a; wide_sel = wd;
    @(negedge clk); d = bus_dout; oe = {bus_oe_hi, bus_oe_lo};
    rd_n = 1'b1; cs_n = 1'b1;
    if (coll) begin res_valid = 1'b1; res_word = cw; end
    @(negedge clk); res_valid = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [1:0] oe;
    logic [15:0] j;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state, R13 ready
    chk("R13 ready", {15'h0, res_ready}, 16'h0001);
    rd(1'b0, 1'b0, 1'b0, '0, d, oe);
    chk("R12 reset status", d, {8'h00, stat(1'b1, 1'b0)});
    rd(1'b1, 1'b1, 1'b0, '0, d, oe);
    chk("R12 reset buffer", d, 16'h0000);

    // R10 idle lanes
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
    #1 chk("R10 cs only", {14'h0, bus_oe_hi, bus_oe_lo}, 16'h0);
    cs_n = 1'b1; rd_n = 1'b0;
    #1 chk("R10 rd only", {14'h0, bus_oe_hi, bus_oe_lo}, 16'h0);
    rd_n = 1'b1;

    // table walk: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      j = {VEC[i], 4'h0};
      load(VEC[i]);
      rd(1'b0, 1'b0, 1'b0, '0, d, oe);
      chk("R6 R7 status after load", d, {8'h00, stat(1'b0, 1'b0)});
      chk("R5 status lanes", {14'h0, oe}, 16'h0001);
      rd(1'b1, 1'b1, 1'b0, '0, d, oe);
      chk("R1 wide data", d, j);
      chk("R1 wide lanes", {14'h0, oe}, 16'h0003);
      rd(1'b1, 1'b0, 1'b0, '0, d, oe);
      chk("R2 high byte", d, {8'h00, j[15:8]});
      chk("R2 lanes", {14'h0, oe}, 16'h0001);
      rd(1'b0, 1'b0, 1'b0, '0, d, oe);
      chk("R7 status low next", d, {8'h00, stat(1'b1, 1'b1)});
      rd(1'b1, 1'b0, 1'b0, '0, d, oe);
      chk("R3 low byte", d, {8'h00, j[7:0]});
      rd(1'b1, 1'b0, 1'b0, '0, d, oe);
      chk("R4 wraps high", d, {8'h00, j[15:8]});
    end

    // R4 reload resets pointer mid-sequence
    load(12'h3C7);
    rd(1'b1, 1'b0, 1'b0, '0, d, oe);
    chk("R4 first high", d, 16'h003C);
    load(12'hE19);
    rd(1'b1, 1'b0, 1'b0, '0, d, oe);
    chk("R4 reload high", d, 16'h00E1);
    rd(1'b1, 1'b0, 1'b0, '0, d, oe);
    chk("R3 reload low", d, 16'h0090);

    // R8 phase flags
    trk_busy = 1'b0; cnv_busy = 1'b1; cal_busy = 1'b1; acq_settle_n = 1'b0;
    rd(1'b0, 1'b0, 1'b0, '0, d, oe);
    chk("R8 phase flags", d, 16'h00C1);
    trk_busy = 1'b1; cnv_busy = 1'b0; cal_busy = 1'b0; acq_settle_n = 1'b1;
    rd(1'b0, 1'b0, 1'b0, '0, d, oe);
    chk("R8 phase flags b", d, 16'h0029);

    // R9 buffer held through activity
    cnv_busy = 1'b1;
    rd(1'b1, 1'b1, 1'b0, '0, d, oe);
    chk("R9 held while converting", d, 16'hE190);
    cnv_busy = 1'b0;

    // R6 data read releases eoc
    load(12'h456);
    rd(1'b1, 1'b1, 1'b0, '0, d, oe);
    rd(1'b0, 1'b0, 1'b0, '0, d, oe);
    chk("R6 released by data read", d, {8'h00, stat(1'b1, 1'b0)});

    // R11 collision: byte read ends as new result loads
    rd(1'b1, 1'b0, 1'b1, 12'h9AB, d, oe);
    chk("R11 read data old", d, 16'h0045);
    rd(1'b0, 1'b0, 1'b0, '0, d, oe);
    chk("R11 eoc low ptr high", d, {8'h00, stat(1'b0, 1'b0)});
    rd(1'b1, 1'b0, 1'b0, '0, d, oe);
    chk("R11 new high byte", d, 16'h009A);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule